// File: doc/BRIEF.md
# Multi-Source Branch Target Selector

This block produces the next-fetch address for a branch in a 32-bit RISC pipeline that keeps a link register and a count register. It picks the target from one of four sources: a sign-extended absolute word field, the current instruction address plus a signed word displacement, the link register, or the count register. The redirect address and its valid flag are combinational outputs in the cycle the branch is presented.

The two special registers live inside the block. A branch may save its return address (current address plus 4) in the link register, and may decrement the count register and make the branch depend on whether the new count is zero or non-zero. Software writes both registers through dedicated write ports. A branch-induced update of a register takes priority over a software write to that same register in the same cycle. Every target has its two low bits cleared, so fetch stays word-aligned.

Top module: `bts_branch_unit`

## Requirements
- R1: Source code 0 (absolute): the target is the 24-bit field, sign-extended, shifted left by 2. The two low bits of every target are zero.
- R2: Source code 1 (relative): the target is `cur_pc` plus the sign-extended field shifted left by 2, wrapping modulo 2^32, with the two low bits cleared.
- R3: Source code 2: the target is the link register value held before the clock edge, with its two low bits cleared. This applies even when the same branch also writes the link register.
- R4: Source code 3: the target is the count register value held before the clock edge, with its two low bits cleared.
- R5: `redirect_valid` is high only when `br_valid` and `cond_true` are both high and the count test passes. It is low in every cycle without `br_valid`.
- R6: When `br_valid` and `link_en` are both high, the link register takes `cur_pc + 4` at the next edge, whether or not the branch is taken. Otherwise the link register holds its value, unless software writes it.
- R7: When `br_valid` and `cnt_dec` are both high, the count register takes its value minus one at the next edge, wrapping from 0 to 0xFFFFFFFF, whether or not the branch is taken.
- R8: Count test code 0 always passes. Code 1 passes when the count is zero. Code 2 passes when the count is non-zero. Code 3 always passes. The value tested is the decremented count when `cnt_dec` is set, and the current count otherwise.
- R9: A software write to either register takes effect at the next edge. It is discarded when a branch updates the same register in the same cycle.
- R10: After reset, both registers read zero and `redirect_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | A decoded branch is present this cycle |
| br_src | input | 2 | Target source: 0 absolute, 1 relative, 2 link, 3 count |
| br_field | input | 24 | Signed word displacement or absolute word address |
| link_en | input | 1 | Save the return address in the link register |
| cnt_dec | input | 1 | Decrement the count register |
| cnt_test | input | 2 | Count condition: 0 none, 1 zero, 2 non-zero, 3 none |
| cond_true | input | 1 | The condition test outside the block is true |
| cur_pc | input | 32 | Address of the branch instruction |
| sw_lr_we | input | 1 | Software write enable for the link register |
| sw_lr_wdata | input | 32 | Software write data for the link register |
| sw_ctr_we | input | 1 | Software write enable for the count register |
| sw_ctr_wdata | input | 32 | Software write data for the count register |
| redirect_valid | output | 1 | The branch is taken; fetch must redirect |
| redirect_addr | output | 32 | Word-aligned target address |
| lr_q | output | 32 | Current link register value |
| ctr_q | output | 32 | Current count register value |

## Verification
The bench targets these corner cases:
- A branch that reads the link register while it also writes it. A design that forwards the new return address would jump to `cur_pc + 4`.
- A count loop run down to zero, and a decrement from zero. A design that tests the old count would take the branch one time too many. A design that saturates would leave zero in place of 0xFFFFFFFF.
- Simultaneous software and branch writes to the same register. A design with the priority reversed would show the software value.
- Backward relative branches, negative absolute fields and registers holding unaligned values. A design with the wrong sign extension or no alignment would produce a wrong upper address or set low bits.
- Branches whose condition is false. A design that updates the link register only on taken branches would leave the link register stale.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    TGT_ABS   = 2'd0,
    TGT_REL   = 2'd1,
    TGT_LINK  = 2'd2,
    TGT_COUNT = 2'd3
  } tgt_src_e;

  typedef enum logic [1:0] {
    CT_ALWAYS  = 2'd0,
    CT_ZERO    = 2'd1,
    CT_NONZERO = 2'd2,
    CT_RSVD    = 2'd3
  } cnt_test_e;

endpackage

// File: rtl/bts_target_calc.sv
module bts_target_calc
  import bts_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 24
) (
  input  tgt_src_e            src,
  input  logic [FIELD_W-1:0]  field,
  input  logic [ADDR_W-1:0]   cur_pc,
  input  logic [ADDR_W-1:0]   lr_q,
  input  logic [ADDR_W-1:0]   ctr_q,
  output logic [ADDR_W-1:0]   target
);
  localparam int EXT_W = ADDR_W - FIELD_W - 2;

  // Word field to a sign-extended byte offset.
  function automatic logic [ADDR_W-1:0] f_byte_off(input logic [FIELD_W-1:0] f);
    return {{EXT_W{f[FIELD_W-1]}}, f, 2'b00};
  endfunction

  // Clear the two low bits of an address.
  function automatic logic [ADDR_W-1:0] f_word_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] raw_target;

  assign offset = f_byte_off(field);

  always_comb begin
    unique case (src)
      TGT_ABS:   raw_target = offset;
      TGT_REL:   raw_target = cur_pc + offset;
      TGT_LINK:  raw_target = lr_q;
      TGT_COUNT: raw_target = ctr_q;
      default:   raw_target = offset;
    endcase
  end

  assign target = f_word_align(raw_target);

endmodule

// File: rtl/bts_count_eval.sv
module bts_count_eval
  import bts_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ctr_q,
  input  logic              dec_en,
  input  cnt_test_e         test,
  output logic [ADDR_W-1:0] ctr_dec_val,
  output logic              test_pass
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  function automatic logic f_test(input cnt_test_e t, input logic [ADDR_W-1:0] v);
    logic is_zero;
    is_zero = (v == '0);
    unique case (t)
      CT_ZERO:    return is_zero;
      CT_NONZERO: return !is_zero;
      default:    return 1'b1;
    endcase
  endfunction

  logic [ADDR_W-1:0] tested_val;

  assign ctr_dec_val = ctr_q - ONE;
  assign tested_val  = dec_en ? ctr_dec_val : ctr_q;
  assign test_pass   = f_test(test, tested_val);

endmodule

// File: rtl/bts_spr_file.sv
module bts_spr_file #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_upd,
  input  logic [ADDR_W-1:0] link_val,
  input  logic              sw_lr_we,
  input  logic [ADDR_W-1:0] sw_lr_wdata,
  input  logic              ctr_upd,
  input  logic [ADDR_W-1:0] ctr_val,
  input  logic              sw_ctr_we,
  input  logic [ADDR_W-1:0] sw_ctr_wdata,
  output logic [ADDR_W-1:0] lr_q,
  output logic [ADDR_W-1:0] ctr_q
);
  logic [ADDR_W-1:0] lr_d, ctr_d;

  always_comb begin
    lr_d = lr_q;
    if (link_upd)      lr_d = link_val;
    else if (sw_lr_we) lr_d = sw_lr_wdata;
  end

  always_comb begin
    ctr_d = ctr_q;
    if (ctr_upd)        ctr_d = ctr_val;
    else if (sw_ctr_we) ctr_d = sw_ctr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q  <= '0;
      ctr_q <= '0;
    end else begin
      lr_q  <= lr_d;
      ctr_q <= ctr_d;
    end
  end

  // R6: the branch update lands at the next edge.
  assert_link_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    link_upd |=> lr_q == $past(link_val));
  // R6: the link register holds when nothing writes it.
  assert_link_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_upd && !sw_lr_we) |=> $stable(lr_q));
  // R9: a software write loses to a branch update.
  assert_sw_lr_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_lr_we && !link_upd) |=> lr_q == $past(sw_lr_wdata));
  assert_sw_ctr_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ctr_we && !ctr_upd) |=> ctr_q == $past(sw_ctr_wdata));

endmodule

// File: rtl/bts_branch_unit.sv
module bts_branch_unit
  import bts_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_valid,
  input  logic [1:0]         br_src,
  input  logic [FIELD_W-1:0] br_field,
  input  logic               link_en,
  input  logic               cnt_dec,
  input  logic [1:0]         cnt_test,
  input  logic               cond_true,
  input  logic [ADDR_W-1:0]  cur_pc,
  input  logic               sw_lr_we,
  input  logic [ADDR_W-1:0]  sw_lr_wdata,
  input  logic               sw_ctr_we,
  input  logic [ADDR_W-1:0]  sw_ctr_wdata,
  output logic               redirect_valid,
  output logic [ADDR_W-1:0]  redirect_addr,
  output logic [ADDR_W-1:0]  lr_q,
  output logic [ADDR_W-1:0]  ctr_q
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  // Named internal events.
  logic              link_upd;
  logic              ctr_upd;
  logic [ADDR_W-1:0] ret_addr;
  logic [ADDR_W-1:0] ctr_dec_val;
  logic              cnt_pass;
  logic [ADDR_W-1:0] target;

  assign link_upd = br_valid && link_en;
  assign ctr_upd  = br_valid && cnt_dec;
  assign ret_addr = cur_pc + INSN_BYTES;

  bts_target_calc #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_target (
    .src    (tgt_src_e'(br_src)),
    .field  (br_field),
    .cur_pc (cur_pc),
    .lr_q   (lr_q),
    .ctr_q  (ctr_q),
    .target (target)
  );

  bts_count_eval #(.ADDR_W(ADDR_W)) u_count (
    .ctr_q       (ctr_q),
    .dec_en      (cnt_dec),
    .test        (cnt_test_e'(cnt_test)),
    .ctr_dec_val (ctr_dec_val),
    .test_pass   (cnt_pass)
  );

  bts_spr_file #(.ADDR_W(ADDR_W)) u_spr (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_upd     (link_upd),
    .link_val     (ret_addr),
    .sw_lr_we     (sw_lr_we),
    .sw_lr_wdata  (sw_lr_wdata),
    .ctr_upd      (ctr_upd),
    .ctr_val      (ctr_dec_val),
    .sw_ctr_we    (sw_ctr_we),
    .sw_ctr_wdata (sw_ctr_wdata),
    .lr_q         (lr_q),
    .ctr_q        (ctr_q)
  );

  assign redirect_valid = br_valid && cond_true && cnt_pass;
  assign redirect_addr  = target;

  // R1: every target is word-aligned.
  assert_target_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> redirect_addr[1:0] == 2'b00);
  // R5: no redirect without a branch.
  assert_no_redirect_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> !redirect_valid);
  // R7: the decrement lands at the next edge.
  assert_ctr_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_upd |=> ctr_q == $past(ctr_q) - INSN_BYTES / 4);
  // R8: a taken zero-test branch with decrement leaves a zero count.
  assert_zero_loop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && cnt_dec && cnt_test == 2'd1) |=> ctr_q == '0);

endmodule

// File: tb/bts_branch_unit_tb_top.sv
module bts_branch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [1:0]  br_src = '0;
  logic [23:0] br_field = '0;
  logic        link_en = 1'b0, cnt_dec = 1'b0, cond_true = 1'b0;
  logic [1:0]  cnt_test = '0;
  logic [31:0] cur_pc = '0;
  logic        sw_lr_we = 1'b0, sw_ctr_we = 1'b0;
  logic [31:0] sw_lr_wdata = '0, sw_ctr_wdata = '0;
  logic        redirect_valid;
  logic [31:0] redirect_addr, lr_q, ctr_q;

  always #10 clk = ~clk;  // 50 MHz

  bts_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src),
    .br_field(br_field), .link_en(link_en), .cnt_dec(cnt_dec),
    .cnt_test(cnt_test), .cond_true(cond_true), .cur_pc(cur_pc),
    .sw_lr_we(sw_lr_we), .sw_lr_wdata(sw_lr_wdata), .sw_ctr_we(sw_ctr_we),
    .sw_ctr_wdata(sw_ctr_wdata), .redirect_valid(redirect_valid),
    .redirect_addr(redirect_addr), .lr_q(lr_q), .ctr_q(ctr_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Scoreboard item: {valid, addr, lr after edge, ctr after edge}.
  typedef struct packed {
    logic        vld;
    logic [31:0] addr;
    logic [31:0] lr;
    logic [31:0] ctr;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];

  // Bench's own register model.
  logic [31:0] m_lr = '0;
  logic [31:0] m_ctr = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic bv, input logic [1:0] src, input logic [23:0] fld,
                       input logic lk, input logic dec, input logic [1:0] tst,
                       input logic cnd, input logic [31:0] pc,
                       input logic lwe, input logic [31:0] lwd,
                       input logic cwe, input logic [31:0] cwd, input string tag);
    exp_t e;
    logic [31:0] off, newc, raw;
    logic pass;
    @(negedge clk);
    br_valid = bv; br_src = src; br_field = fld; link_en = lk; cnt_dec = dec;
    cnt_test = tst; cond_true = cnd; cur_pc = pc; sw_lr_we = lwe;
    sw_lr_wdata = lwd; sw_ctr_we = cwe; sw_ctr_wdata = cwd;
    off  = {{6{fld[23]}}, fld, 2'b00};
    newc = dec ? m_ctr - 32'd1 : m_ctr;
    if (tst == 2'd1)      pass = (newc == 32'd0);
    else if (tst == 2'd2) pass = (newc != 32'd0);
    else                  pass = 1'b1;
    case (src)
      2'd0: raw = off;
      2'd1: raw = pc + off;
      2'd2: raw = m_lr;
      default: raw = m_ctr;
    endcase
    e.vld  = bv & cnd & pass;
    e.addr = raw & 32'hFFFF_FFFC;
    e.lr   = (bv && lk) ? pc + 32'd4 : (lwe ? lwd : m_lr);
    e.ctr  = (bv && dec) ? m_ctr - 32'd1 : (cwe ? cwd : m_ctr);
    m_lr  = e.lr;
    m_ctr = e.ctr;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 2'd0, 24'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,
          1'b0, 32'h0, 1'b0, 32'h0, tag);
  endtask

  // Monitor: combinational results mid low phase, registers after the edge.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (expq.size() > 0) begin
        exp_t e;
        string t;
        e = expq[0];
        t = tagq[0];
        check(redirect_valid == e.vld, t, "redirect_valid",
              {31'd0, redirect_valid}, {31'd0, e.vld});
        if (e.vld) check(redirect_addr == e.addr, t, "redirect_addr", redirect_addr, e.addr);
        @(posedge clk);
        #1;
        check(lr_q == e.lr, t, "lr_q", lr_q, e.lr);
        check(ctr_q == e.ctr, t, "ctr_q", ctr_q, e.ctr);
        void'(expq.pop_front());
        void'(tagq.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(lr_q == 32'd0, "R10", "lr_q reset", lr_q, 32'd0);
    check(ctr_q == 32'd0, "R10", "ctr_q reset", ctr_q, 32'd0);
    check(redirect_valid == 1'b0, "R10", "redirect_valid reset",
          {31'd0, redirect_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: absolute, positive and negative fields
    drive(1, 2'd0, 24'h00_1234, 0, 0, 2'd0, 1, 32'h0000_1000, 0, 0, 0, 0, "R1");
    drive(1, 2'd0, 24'hFF_FFF0, 0, 0, 2'd0, 1, 32'h0000_1000, 0, 0, 0, 0, "R1");
    // R2: relative forward, backward, and wrap
    drive(1, 2'd1, 24'h00_0010, 0, 0, 2'd0, 1, 32'h0000_2000, 0, 0, 0, 0, "R2");
    drive(1, 2'd1, 24'hFF_FFFE, 0, 0, 2'd0, 1, 32'h0000_2000, 0, 0, 0, 0, "R2");
    drive(1, 2'd1, 24'h00_0004, 0, 0, 2'd0, 1, 32'hFFFF_FFF8, 0, 0, 0, 0, "R2");
    // R6: taken relative branch with link
    drive(1, 2'd1, 24'h00_0100, 1, 0, 2'd0, 1, 32'h0000_4000, 0, 0, 0, 0, "R6");
    // R3: link target while also writing the link register
    drive(1, 2'd2, 24'h0, 1, 0, 2'd0, 1, 32'h0000_8000, 0, 0, 0, 0, "R3");
    // R3: unaligned link value is aligned
    drive(0, 2'd0, 24'h0, 0, 0, 2'd0, 0, 32'h0, 1, 32'h1234_5677, 0, 0, "R9");
    drive(1, 2'd2, 24'h0, 0, 0, 2'd0, 1, 32'h0000_9000, 0, 0, 0, 0, "R3");
    // R9 and R4: software write of count, then count target
    drive(0, 2'd0, 24'h0, 0, 0, 2'd0, 0, 32'h0, 0, 0, 1, 32'h0000_0003, "R9");
    drive(1, 2'd3, 24'h0, 0, 0, 2'd0, 1, 32'h0000_A000, 0, 0, 0, 0, "R4");
    // R7, R8: loop counted down with the non-zero test, 3 -> 2 -> 1 -> 0
    drive(1, 2'd1, 24'hFF_FFFC, 0, 1, 2'd2, 1, 32'h0000_B010, 0, 0, 0, 0, "R8");
    drive(1, 2'd1, 24'hFF_FFFC, 0, 1, 2'd2, 1, 32'h0000_B010, 0, 0, 0, 0, "R8");
    drive(1, 2'd1, 24'hFF_FFFC, 0, 1, 2'd2, 1, 32'h0000_B010, 0, 0, 0, 0, "R8");
    // R7: decrement from zero wraps (zero test on new value fails)
    drive(1, 2'd0, 24'h00_0040, 0, 1, 2'd1, 1, 32'h0000_C000, 0, 0, 0, 0, "R7");
    // R8: zero test without decrement on non-zero count
    drive(1, 2'd0, 24'h00_0040, 0, 0, 2'd1, 1, 32'h0000_C000, 0, 0, 0, 0, "R8");
    drive(0, 2'd0, 24'h0, 0, 0, 2'd0, 0, 32'h0, 0, 0, 1, 32'h0, "R9");
    drive(1, 2'd0, 24'h00_0040, 0, 0, 2'd1, 1, 32'h0000_C000, 0, 0, 0, 0, "R8");
    // R8: reserved code 3 always passes
    drive(1, 2'd0, 24'h00_0080, 0, 0, 2'd3, 1, 32'h0000_C000, 0, 0, 0, 0, "R8");
    // R5, R6: condition false, link still written
    drive(1, 2'd0, 24'h00_0080, 1, 0, 2'd0, 0, 32'h0000_D000, 0, 0, 0, 0, "R5");
    // R9: simultaneous software and branch writes, branch wins
    drive(1, 2'd0, 24'h00_0020, 1, 1, 2'd0, 1, 32'h0000_E000,
          1, 32'hDEAD_BEEC, 1, 32'h0000_0055, "R9");
    // R5, R6: no branch, fields ignored, registers hold
    drive(0, 2'd2, 24'h12_3456, 1, 1, 2'd0, 1, 32'h0000_F000, 0, 0, 0, 0, "R5");
    idle("R6");
    idle("R7");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule